// File: doc/BRIEF.md
# Prescaled Countdown Timer

A private down-counting timer attached to a simple 32-bit word-access register bus. Software programs a reload value, a live count, a control word and reads or acknowledges a sticky event flag. While enabled, the count drops by one every (prescaler + 1) clock cycles. When it reaches zero the event flag is set and, if interrupts are enabled, the interrupt output is raised. The timer then either halts (single-shot mode) or picks up the reload value and keeps going (repeating mode).

Writes of zero to the reload or count register while the prescaler is zero are treated specially: instead of producing an event they halt the timer, or in repeating mode with a nonzero reload value, a zero count write is replaced by the reload value. In repeating mode with a reload value of zero, the event repeats every prescaler period when the prescaler is nonzero, and the timer halts after one event when it is zero.

Top module: `cdt_timer`

## Requirements
- R1: Register word offsets: 0x0 reload value, 0x4 live count, 0x8 control, 0xC event status; reads at any other offset return zero. Control reads back only bit 0 (run enable), bit 1 (repeat mode), bit 2 (interrupt enable) and bits 15:8 (prescaler); all other bits read zero.
- R2: After synchronous reset the reload, count, control and status registers read zero, the interrupt output is low and the timer is halted.
- R3: After a control write that enables counting with count N (N nonzero) and prescaler P, the event is raised exactly (P+1)*N clock edges after the write edge.
- R4: The event status (bit 0 of 0xC) is sticky, and the interrupt output always equals status AND interrupt enable, both changing on the same edge.
- R5: Writing 1 to status bit 0 clears the flag and drops the interrupt on that write's edge; writing 0 leaves it set.
- R6: In single-shot mode the timer halts with count zero after the event and the count then stays unchanged.
- R7: In repeating mode with nonzero reload value L, events recur every (P+1)*L cycles.
- R8: A reload write of zero while enabled with prescaler zero halts the timer without an event.
- R9: With prescaler zero and enable set, a count write of zero halts the timer without an event in single-shot mode; in repeating mode with nonzero reload value the count is set to the reload value instead.
- R10: In repeating mode with reload value zero, a nonzero prescaler P re-raises the event every P+1 cycles, while prescaler zero halts the timer after one event.
- R11: A control write that enables repeating mode while the count is zero first loads the count from the reload value.
- R12: A read returns, one edge later on the read data port, the register value held at the read edge; the count read is the live value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | ADDR_W | Byte address (bits 1:0 ignored) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The assertions assume that at most one register access happens per cycle and that a write to the reload, count or control register takes precedence over a prescaler tick in the same cycle, so a counter change with no write in the previous cycle must be a decrement, a reload or a drop to zero. They also assume that status rises only through a countdown event, never through a bus write. The stimulus issues one access per cycle from a task, always starts from a halted timer with a cleared flag, and sweeps prescaler and count values small enough that every event edge can be predicted arithmetically.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
  // word index of each register
  localparam int unsigned IDX_RELOAD = 0;
  localparam int unsigned IDX_COUNT  = 1;
  localparam int unsigned IDX_CTRL   = 2;
  localparam int unsigned IDX_STAT   = 3;
  // control bit positions (software-visible, fixed)
  localparam int unsigned CB_RUN     = 0;
  localparam int unsigned CB_REPEAT  = 1;
  localparam int unsigned CB_IRQEN   = 2;
  localparam int unsigned CB_PSC_LSB = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RELOAD,
    SEL_COUNT,
    SEL_CTRL,
    SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/cdt_regif.sv
`timescale 1ns/1ps
module cdt_regif
  import cdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PSC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_reload,
  output logic              wr_count,
  output logic              wr_ctrl,
  output logic              wr_stat,
  input  logic [CNT_W-1:0]  reload_v,
  input  logic [CNT_W-1:0]  count_v,
  input  logic              run_en,
  input  logic              repeat_en,
  input  logic              irq_en,
  input  logic [PSC_W-1:0]  psc_v,
  input  logic              status_v,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  word_idx;
  reg_sel_e          sel;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign word_idx = bus_addr[ADDR_W-1:2];

  always_comb begin
    case (word_idx)
      IDX_W'(IDX_RELOAD): sel = SEL_RELOAD;
      IDX_W'(IDX_COUNT):  sel = SEL_COUNT;
      IDX_W'(IDX_CTRL):   sel = SEL_CTRL;
      IDX_W'(IDX_STAT):   sel = SEL_STAT;
      default:            sel = SEL_NONE;
    endcase
  end

  assign wr_reload = bus_wr && (sel == SEL_RELOAD);
  assign wr_count  = bus_wr && (sel == SEL_COUNT);
  assign wr_ctrl   = bus_wr && (sel == SEL_CTRL);
  assign wr_stat   = bus_wr && (sel == SEL_STAT);

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CB_RUN]    = run_en;
    ctrl_word[CB_REPEAT] = repeat_en;
    ctrl_word[CB_IRQEN]  = irq_en;
    ctrl_word[CB_PSC_LSB +: PSC_W] = psc_v;
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_RELOAD: rd_mux = DATA_W'(reload_v);
      SEL_COUNT:  rd_mux = DATA_W'(count_v);
      SEL_CTRL:   rd_mux = ctrl_word;
      SEL_STAT:   rd_mux[0] = status_v;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_mux;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/cdt_prescaler.sv
`timescale 1ns/1ps
module cdt_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] div_q;
  logic             at_end;

  assign at_end = (div_q == psc);
  assign tick   = run && !restart && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      div_q <= '0;
    end else if (at_end) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/cdt_core.sv
`timescale 1ns/1ps
module cdt_core
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PSC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_reload,
  input  logic              wr_count,
  input  logic              wr_ctrl,
  input  logic              wr_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  output logic [CNT_W-1:0]  reload_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              run_en_q,
  output logic              repeat_q,
  output logic              irq_en_q,
  output logic [PSC_W-1:0]  psc_q,
  output logic              running_q,
  output logic              status_q,
  output logic              irq_q
);
  logic [CNT_W-1:0] reload_n, count_n, wval, eff;
  logic             run_en_n, repeat_n, irq_en_n, running_n, status_n, event_hit;
  logic [PSC_W-1:0] psc_n;
  logic             w_run, w_rep, w_ie;
  logic [PSC_W-1:0] w_psc;

  assign wval  = CNT_W'(wdata);
  assign w_run = wdata[CB_RUN];
  assign w_rep = wdata[CB_REPEAT];
  assign w_ie  = wdata[CB_IRQEN];
  assign w_psc = wdata[CB_PSC_LSB +: PSC_W];

  always_comb begin
    reload_n  = reload_q;
    count_n   = count_q;
    run_en_n  = run_en_q;
    repeat_n  = repeat_q;
    irq_en_n  = irq_en_q;
    psc_n     = psc_q;
    running_n = running_q;
    event_hit = 1'b0;
    eff       = '0;
    if (wr_reload) begin
      reload_n  = wval;
      count_n   = wval;
      running_n = run_en_q && ((psc_q != '0) || (wval != '0));
    end else if (wr_count) begin
      eff = (run_en_q && repeat_q && (psc_q == '0) && (wval == '0)) ? reload_q : wval;
      count_n   = eff;
      running_n = run_en_q && ((psc_q != '0) || (eff != '0));
    end else if (wr_ctrl) begin
      run_en_n = w_run;
      repeat_n = w_rep;
      irq_en_n = w_ie;
      psc_n    = w_psc;
      eff = (w_rep && (count_q == '0)) ? reload_q : count_q;
      if (w_run) begin
        count_n = eff;
      end
      running_n = w_run && ((w_psc != '0) || (eff != '0));
    end else if (tick) begin
      if (count_q > CNT_W'(1)) begin
        count_n = count_q - 1'b1;
      end else begin
        event_hit = 1'b1;
        count_n   = repeat_q ? reload_q : '0;
        if ((count_n == '0) && (!repeat_q || (psc_q == '0))) begin
          running_n = 1'b0;
        end
      end
    end
    status_n = (status_q && !(wr_stat && wdata[0])) || event_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q  <= '0;
      count_q   <= '0;
      run_en_q  <= 1'b0;
      repeat_q  <= 1'b0;
      irq_en_q  <= 1'b0;
      psc_q     <= '0;
      running_q <= 1'b0;
      status_q  <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      reload_q  <= reload_n;
      count_q   <= count_n;
      run_en_q  <= run_en_n;
      repeat_q  <= repeat_n;
      irq_en_q  <= irq_en_n;
      psc_q     <= psc_n;
      running_q <= running_n;
      status_q  <= status_n;
      irq_q     <= status_n && irq_en_n;
    end
  end
endmodule

// File: rtl/cdt_timer.sv
`timescale 1ns/1ps
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PSC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic             wr_reload, wr_count, wr_ctrl, wr_stat, tick, restart;
  logic [CNT_W-1:0] reload_w, count_w;
  logic             run_en_w, repeat_w, irq_en_w, running_w, status_w, irq_w;
  logic [PSC_W-1:0] psc_w;

  assign restart = wr_reload || wr_count || wr_ctrl;

  cdt_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regif (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .wr_reload(wr_reload), .wr_count(wr_count), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
    .reload_v(reload_w), .count_v(count_w), .run_en(run_en_w), .repeat_en(repeat_w),
    .irq_en(irq_en_w), .psc_v(psc_w), .status_v(status_w), .rdata(bus_rdata)
  );

  cdt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run(running_w), .restart(restart), .psc(psc_w), .tick(tick)
  );

  cdt_core #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
    .clk(clk), .rst(rst), .wr_reload(wr_reload), .wr_count(wr_count), .wr_ctrl(wr_ctrl),
    .wr_stat(wr_stat), .wdata(bus_wdata), .tick(tick), .reload_q(reload_w),
    .count_q(count_w), .run_en_q(run_en_w), .repeat_q(repeat_w), .irq_en_q(irq_en_w),
    .psc_q(psc_w), .running_q(running_w), .status_q(status_w), .irq_q(irq_w)
  );

  assign irq_o = irq_w;
endmodule

// File: rtl/cdt_timer_chk.sv
`timescale 1ns/1ps
module cdt_timer_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PSC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_o,
  input logic              status,
  input logic              running,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload,
  input logic              run_en,
  input logic              repeat_en,
  input logic              irq_en,
  input logic [PSC_W-1:0]  psc
);
  logic [ADDR_W-3:0] widx;
  assign widx = bus_addr[ADDR_W-1:2];

  assert_reset_quiet_R2: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && !status && !running));

  assert_irq_gate_R4: assert property (@(posedge clk) disable iff (rst)
    irq_o == (status && irq_en));

  assert_w1c_only_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(status) |-> $past(bus_wr && (widx == 3) && bus_wdata[0]));

  assert_oneshot_halt_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(status) && !repeat_en) |-> !running);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!running && !bus_wr) |=> $stable(count));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(running) && !$past(bus_wr) && (count != $past(count))) |->
      ((count == $past(count) - 1'b1) || (count == reload) || (count == '0)));

  assert_reload_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (widx == 0) && (bus_wdata == '0) && run_en && (psc == '0))
      |=> (!running && !$rose(status)));
endmodule

bind cdt_timer cdt_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq_o(irq_o), .status(status_w), .running(running_w), .count(count_w),
  .reload(reload_w), .run_en(run_en_w), .repeat_en(repeat_w), .irq_en(irq_en_w),
  .psc(psc_w)
);

// File: tb/tb_cdt_timer.sv
`timescale 1ns/1ps
module tb_cdt_timer;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_RLD = 5'h00, A_CNT = 5'h04, A_CTL = 5'h08, A_STA = 5'h0C;
  localparam logic [31:0] C_RUN = 32'h1, C_REP = 32'h2, C_IE = 32'h4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic irq_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cdt_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // each task starts and ends at a falling edge and spans one rising edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic halt_clear();
    wr(A_CTL, 32'h0);
    wr(A_STA, 32'h1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] r;
    int t;
    idle(3);
    rst = 1'b0;

    // R2 reset state
    check("R2 irq", {31'b0, irq_o}, 32'h0);
    rd(A_RLD, r); check("R2 reload", r, 0);
    rd(A_CNT, r); check("R2 count", r, 0);
    rd(A_CTL, r); check("R2 ctrl", r, 0);
    rd(A_STA, r); check("R2 status", r, 0);

    // R1 map, unmapped reads, control bit filtering
    wr(A_RLD, 32'h0000_0007);
    rd(A_RLD, r); check("R1 reload", r, 32'h7);
    rd(A_CNT, r); check("R1 count", r, 32'h7);
    rd(5'h10, r); check("R1 unmapped10", r, 0);
    rd(5'h1C, r); check("R1 unmapped1C", r, 0);
    wr(A_CTL, 32'hFFFF_FFF8);
    rd(A_CTL, r); check("R1 ctrl bits", r, 32'h0000_FF00);
    rd(A_CNT, r); check("R6 count held while disabled", r, 32'h7);

    // R3/R4/R5/R6/R12 single-shot sweep
    for (int p = 0; p < 4; p++) begin
      for (int v = 1; v < 5; v++) begin
        halt_clear();
        wr(A_RLD, v);
        wr(A_CTL, (p << 8) | C_RUN | C_IE);
        t = (p + 1) * v;
        if (v >= 2) begin
          rd(A_CNT, r); check("R12 live count", r, v);
          idle(t - 2);
        end else begin
          idle(t - 1);
        end
        check("R3 no event early", {31'b0, irq_o}, 0);
        idle(1);
        check("R3 event edge", {31'b0, irq_o}, 1);
        rd(A_STA, r); check("R4 status set", r, 1);
        rd(A_CNT, r); check("R6 count zero", r, 0);
        idle(3 * (p + 1));
        check("R4 sticky irq", {31'b0, irq_o}, 1);
        rd(A_CNT, r); check("R6 stays halted", r, 0);
        wr(A_STA, 32'h0);
        check("R5 write0 keeps", {31'b0, irq_o}, 1);
        wr(A_STA, 32'h1);
        check("R5 write1 clears", {31'b0, irq_o}, 0);
      end
    end

    // R4 gating: event with interrupt disabled, then enable
    halt_clear();
    wr(A_RLD, 2);
    wr(A_CTL, C_RUN);
    idle(4);
    check("R4 gated off", {31'b0, irq_o}, 0);
    rd(A_STA, r); check("R4 status w/o irq", r, 1);
    wr(A_CTL, C_RUN | C_IE);
    check("R4 gate on", {31'b0, irq_o}, 1);

    // R7 repeating reload, P=1 L=3
    halt_clear();
    wr(A_RLD, 3);
    wr(A_CTL, (1 << 8) | C_RUN | C_REP | C_IE);
    idle(5); check("R7 first early", {31'b0, irq_o}, 0);
    idle(1); check("R7 first event", {31'b0, irq_o}, 1);
    wr(A_STA, 1); check("R7 cleared", {31'b0, irq_o}, 0);
    idle(4); check("R7 second early", {31'b0, irq_o}, 0);
    idle(1); check("R7 second event", {31'b0, irq_o}, 1);

    // R8 reload write zero while running, prescaler zero
    halt_clear();
    wr(A_RLD, 5);
    wr(A_CTL, C_RUN | C_IE);
    wr(A_RLD, 0);
    idle(10);
    check("R8 no event", {31'b0, irq_o}, 0);
    rd(A_CNT, r); check("R8 count zero", r, 0);

    // R9 count write zero, single-shot
    halt_clear();
    wr(A_RLD, 6);
    wr(A_CTL, C_RUN | C_IE);
    wr(A_CNT, 0);
    idle(10);
    check("R9 oneshot no event", {31'b0, irq_o}, 0);
    rd(A_CNT, r); check("R9 oneshot count", r, 0);

    // R9 count write zero, repeating with reload 4
    halt_clear();
    wr(A_RLD, 4);
    wr(A_CTL, C_RUN | C_REP | C_IE);
    wr(A_CNT, 0);
    rd(A_CNT, r); check("R9 periodic reloads", r, 4);

    // R10 repeating, reload zero, P=2
    halt_clear();
    wr(A_RLD, 0);
    wr(A_CTL, (2 << 8) | C_RUN | C_REP | C_IE);
    idle(2); check("R10 p2 early", {31'b0, irq_o}, 0);
    idle(1); check("R10 p2 event", {31'b0, irq_o}, 1);
    wr(A_STA, 1); check("R10 p2 cleared", {31'b0, irq_o}, 0);
    idle(1); check("R10 p2 gap", {31'b0, irq_o}, 0);
    idle(1); check("R10 p2 refire", {31'b0, irq_o}, 1);

    // R10 repeating, reload zero, P=0: one event then halt
    halt_clear();
    wr(A_RLD, 0);
    wr(A_CNT, 2);
    wr(A_CTL, C_RUN | C_REP | C_IE);
    idle(1); check("R10 p0 early", {31'b0, irq_o}, 0);
    idle(1); check("R10 p0 event", {31'b0, irq_o}, 1);
    wr(A_STA, 1);
    idle(10);
    check("R10 p0 halted", {31'b0, irq_o}, 0);
    rd(A_CNT, r); check("R10 p0 count", r, 0);

    // R11 enable repeating with count zero reloads first
    halt_clear();
    wr(A_RLD, 3);
    wr(A_CNT, 0);
    wr(A_CTL, C_RUN | C_REP | C_IE);
    idle(2); check("R11 early", {31'b0, irq_o}, 0);
    idle(1); check("R11 event after reload", {31'b0, irq_o}, 1);
    halt_clear();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule